// File: doc/BRIEF.md
# Dual-Bank Error Status Controller

This block records hardware error events in two parallel banks of sticky status registers. One bank is read and cleared by a host processor. The other serves a management controller. Every event pulse sets the matching bit in both banks at once. Each bank then keeps that bit until its own side clears it. The host bank is always cleared by writing ones. The management bank can be switched between clearing by writing ones and clearing by reading.

Two designated error sources can each be armed to freeze a bank. Once the armed source's bit is set in a bank, that bank stops capturing every other event. It stays frozen until that source's bit is cleared there. The two banks freeze and release independently. A one-bit OR of each bank is visible to software, and the management bank's OR drives an alert pin, gated by an enable. The control register also exports a command that forces all fan PWM channels to full duty, and a tachometer edge-type selection. Both go to neighbouring fan logic.

The register port is a single-cycle access port. Read data is combinational from the address, and any clear-on-read takes effect at the clock edge that ends the access.

Top module: `dual_bank_errstat`

## Requirements
- R1: After reset the control register reads 00h and every status bit in both banks reads 0. Address 00h is the control register. Its writable fields are: bit 0 selects management clear-on-read, bit 1 arms freeze source A, bit 2 arms freeze source B, bit 3 is the fan full-duty command, and bits 5:4 are the tach edge field. Bit 6 is the host summary and bit 7 is the management summary; both are read-only.
- R2: An event bit held high in a cycle sets the same flat bit position in both banks at the next clock edge. Event bit k maps to status register k/8, bit k%8. Host register i sits at address 10h+i and management register i at 20h+i. A set bit stays set until it is cleared.
- R3: Host status bits are cleared only by writing 1 to them. Bits written with 0 are unchanged, and reads never clear host bits.
- R4: When control bit 0 is 0, management status bits are cleared only by writing 1 to them, and reads do not clear them. A host write leaves the management bank unchanged.
- R5: When control bit 0 is 1, a read of a management register returns its current value and clears all its bits at that edge. Writes to management registers are then ignored.
- R6: An event that arrives in the same cycle as a clear of its bit wins, so the bit stays set.
- R7: When control bit 1 is set and a bank holds the source-A bit (flat bit SRC_A), that bank ignores all other events until that bit is cleared. Capture resumes in the cycle after the clear. The source's own event is still captured, as is source B's if source B is armed.
- R8: Control bit 2 does the same for source B (flat bit SRC_B). With both sources armed, either stored bit freezes the bank.
- R9: Control bit 6 is the OR of all host bits and bit 7 is the OR of all management bits. Writes to these two bits have no effect. alert_o is high exactly when bit 7 is set and alert_en_i is high.
- R10: fan_full_o follows control bit 3.
- R11: tach_edge_o follows control bits 5:4. The codes are 00 for either edge, 01 for rising only, 10 for falling only, and 11 reserved. The field applies to all tach inputs.
- R12: Reads of unmapped addresses, including register indices at or above NUM_REGS, return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (drives clear-on-read) |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| err_evt_i | input | NUM_REGS*8 | Error event pulses, one per status bit |
| alert_en_i | input | 1 | Enables the alert output |
| alert_o | output | 1 | Management-bank alert |
| fan_full_o | output | 1 | Command for all fan PWM channels to run at 100% duty |
| tach_edge_o | output | 2 | Tach edge selection for all tach inputs |

## Verification
The bench builds the block with NUM_REGS=4 and places both freeze sources in status register 1 (SRC_A=12, SRC_B=13). This layout lets one register read show whether the armed source, the unarmed source, or both were captured while a bank is frozen. Register index 4 then lies inside a decoded page but beyond the last register, which exercises the unmapped-index read path. With four registers, separate registers can be cleared in each bank while the other bank keeps its frozen state. This makes the independent release of the two banks visible.

// File: rtl/errstat_pkg.sv
package errstat_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int CTL_W     = 6;
    localparam int PAGE_W    = 4;

    localparam logic [ADDR_W-1:0] CTL_ADDR  = 8'h00;
    localparam logic [PAGE_W-1:0] HOST_PAGE = 4'h1;
    localparam logic [PAGE_W-1:0] MGMT_PAGE = 4'h2;

    // Tach edge selection shared with the fan logic
    typedef enum logic [1:0] {
        EDGE_ANY  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_RSVD = 2'b11
    } edge_sel_e;

    // Writable control fields, bit 0 at the bottom
    typedef struct packed {
        edge_sel_e edge_sel;   // bits 5:4
        logic      fan_full;   // bit 3
        logic      frz_b_en;   // bit 2
        logic      frz_a_en;   // bit 1
        logic      cor_mode;   // bit 0
    } ctl_t;

    typedef enum logic [1:0] {
        RG_NONE,
        RG_CTL,
        RG_HOST,
        RG_MGMT
    } region_e;

    function automatic region_e region_of(input logic [ADDR_W-1:0] a,
                                          input int unsigned nregs);
        logic [PAGE_W-1:0] page;
        logic [PAGE_W-1:0] idx;
        page = a[ADDR_W-1:PAGE_W];
        idx  = a[PAGE_W-1:0];
        if (a == CTL_ADDR)
            return RG_CTL;
        if (page == HOST_PAGE && 32'(idx) < nregs)
            return RG_HOST;
        if (page == MGMT_PAGE && 32'(idx) < nregs)
            return RG_MGMT;
        return RG_NONE;
    endfunction

endpackage

// File: rtl/errstat_ctl_reg.sv
module errstat_ctl_reg
    import errstat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [CTL_W-1:0] wdata_i,
    output ctl_t             ctl_o
);

    ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= '0;
        else if (wr_i)
            ctl_q <= ctl_t'(wdata_i);
    end

    assign ctl_o = ctl_q;

endmodule

// File: rtl/errstat_decode.sv
module errstat_decode
    import errstat_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
)(
    input  logic                wr_en_i,
    input  logic                rd_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    output logic                ctl_wr_o,
    output logic [NUM_REGS-1:0] host_wr_o,
    output logic [NUM_REGS-1:0] mgmt_wr_o,
    output logic [NUM_REGS-1:0] mgmt_rd_o,
    output region_e             region_o,
    output logic [IDX_W-1:0]    idx_o
);

    region_e region;

    assign region   = region_of(addr_i, NUM_REGS);
    assign region_o = region;
    assign idx_o    = addr_i[IDX_W-1:0];
    assign ctl_wr_o = wr_en_i && (region == RG_CTL);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        logic hit;
        assign hit          = (addr_i[PAGE_W-1:0] == PAGE_W'(i));
        assign host_wr_o[i] = wr_en_i && (region == RG_HOST) && hit;
        assign mgmt_wr_o[i] = wr_en_i && (region == RG_MGMT) && hit;
        assign mgmt_rd_o[i] = rd_en_i && (region == RG_MGMT) && hit;
    end

endmodule

// File: rtl/errstat_bank.sv
module errstat_bank
    import errstat_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int SRC_A    = 12,
    parameter int SRC_B    = 13,
    parameter bit COR_OK   = 1'b0
)(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_REGS*DATA_W-1:0]   evt_i,
    input  logic                         frz_a_en_i,
    input  logic                         frz_b_en_i,
    input  logic                         cor_mode_i,
    input  logic [NUM_REGS-1:0]          wr_sel_i,
    input  logic [NUM_REGS-1:0]          rd_sel_i,
    input  logic [DATA_W-1:0]            wdata_i,
    output logic [NUM_REGS*DATA_W-1:0]   stat_o,
    output logic                         any_o
);

    localparam int EVT_W = NUM_REGS * DATA_W;

    logic [EVT_W-1:0] stat_q;
    logic [EVT_W-1:0] stat_d;
    logic [EVT_W-1:0] cap_mask;
    logic [EVT_W-1:0] clr_vec;
    logic             frozen;
    logic             cor_act;

    assign cor_act = COR_OK && cor_mode_i;

    // Freeze is taken from stored bits, so a release shows one cycle after a clear
    assign frozen = (frz_a_en_i && stat_q[SRC_A]) || (frz_b_en_i && stat_q[SRC_B]);

    always_comb begin
        if (!frozen) begin
            cap_mask = '1;
        end else begin
            cap_mask        = '0;
            cap_mask[SRC_A] = frz_a_en_i;
            cap_mask[SRC_B] = frz_b_en_i;
        end
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_clr
        assign clr_vec[i*DATA_W +: DATA_W] =
            cor_act     ? {DATA_W{rd_sel_i[i]}} :
            wr_sel_i[i] ? wdata_i               : '0;
    end

    // Set beats clear
    assign stat_d = (stat_q & ~clr_vec) | (evt_i & cap_mask);

    always_ff @(posedge clk) begin
        if (rst)
            stat_q <= '0;
        else
            stat_q <= stat_d;
    end

    assign stat_o = stat_q;
    assign any_o  = |stat_q;

endmodule

// File: rtl/dual_bank_errstat.sv
module dual_bank_errstat
    import errstat_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int SRC_A    = 12,
    parameter int SRC_B    = 13
)(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       reg_wr_en,
    input  logic                       reg_rd_en,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [DATA_W-1:0]          reg_wdata,
    output logic [DATA_W-1:0]          reg_rdata,
    input  logic [NUM_REGS*DATA_W-1:0] err_evt_i,
    input  logic                       alert_en_i,
    output logic                       alert_o,
    output logic                       fan_full_o,
    output logic [1:0]                 tach_edge_o
);

    localparam int EVT_W = NUM_REGS * DATA_W;
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    ctl_t                ctl;
    logic                ctl_wr;
    logic [NUM_REGS-1:0] host_wr;
    logic [NUM_REGS-1:0] mgmt_wr;
    logic [NUM_REGS-1:0] mgmt_rd;
    region_e             rd_region;
    logic [IDX_W-1:0]    rd_idx;
    logic [EVT_W-1:0]    host_flat;
    logic [EVT_W-1:0]    mgmt_flat;
    logic                host_any;
    logic                mgmt_any;

    errstat_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_dec (
        .wr_en_i   (reg_wr_en),
        .rd_en_i   (reg_rd_en),
        .addr_i    (reg_addr),
        .ctl_wr_o  (ctl_wr),
        .host_wr_o (host_wr),
        .mgmt_wr_o (mgmt_wr),
        .mgmt_rd_o (mgmt_rd),
        .region_o  (rd_region),
        .idx_o     (rd_idx)
    );

    errstat_ctl_reg u_ctl (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (ctl_wr),
        .wdata_i (reg_wdata[CTL_W-1:0]),
        .ctl_o   (ctl)
    );

    errstat_bank #(
        .NUM_REGS (NUM_REGS),
        .SRC_A    (SRC_A),
        .SRC_B    (SRC_B),
        .COR_OK   (1'b0)
    ) u_host (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (err_evt_i),
        .frz_a_en_i (ctl.frz_a_en),
        .frz_b_en_i (ctl.frz_b_en),
        .cor_mode_i (1'b0),
        .wr_sel_i   (host_wr),
        .rd_sel_i   ('0),
        .wdata_i    (reg_wdata),
        .stat_o     (host_flat),
        .any_o      (host_any)
    );

    errstat_bank #(
        .NUM_REGS (NUM_REGS),
        .SRC_A    (SRC_A),
        .SRC_B    (SRC_B),
        .COR_OK   (1'b1)
    ) u_mgmt (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (err_evt_i),
        .frz_a_en_i (ctl.frz_a_en),
        .frz_b_en_i (ctl.frz_b_en),
        .cor_mode_i (ctl.cor_mode),
        .wr_sel_i   (mgmt_wr),
        .rd_sel_i   (mgmt_rd),
        .wdata_i    (reg_wdata),
        .stat_o     (mgmt_flat),
        .any_o      (mgmt_any)
    );

    always_comb begin
        case (rd_region)
            RG_CTL:  reg_rdata = {mgmt_any, host_any, ctl};
            RG_HOST: reg_rdata = host_flat[rd_idx*DATA_W +: DATA_W];
            RG_MGMT: reg_rdata = mgmt_flat[rd_idx*DATA_W +: DATA_W];
            default: reg_rdata = '0;
        endcase
    end

    assign alert_o     = mgmt_any && alert_en_i;
    assign fan_full_o  = ctl.fan_full;
    assign tach_edge_o = ctl.edge_sel;

endmodule

// File: rtl/errstat_checker.sv
module errstat_checker
    import errstat_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int SRC_A    = 12,
    parameter int SRC_B    = 13
)(
    input logic                       clk,
    input logic                       rst,
    input logic                       wr_en,
    input logic                       rd_en,
    input logic [ADDR_W-1:0]          addr,
    input logic [NUM_REGS*DATA_W-1:0] evt,
    input logic [NUM_REGS*DATA_W-1:0] host_st,
    input logic [NUM_REGS*DATA_W-1:0] mgmt_st,
    input logic                       frz_a_en,
    input logic                       frz_b_en,
    input logic                       cor_mode,
    input logic                       alert_en_i,
    input logic                       alert_o,
    input logic                       fan_full_o,
    input logic [1:0]                 tach_edge_o
);

    localparam int EVT_W = NUM_REGS * DATA_W;
    localparam logic [EVT_W-1:0] ONE  = 1;
    localparam logic [EVT_W-1:0] KEEP = ~((ONE << SRC_A) | (ONE << SRC_B));

    // R2: unfrozen capture lands in both banks
    a_r2_capture_both: assert property (@(posedge clk) disable iff (rst)
        (!frz_a_en && !frz_b_en && evt[0]) |=> (host_st[0] && mgmt_st[0]));

    // R3: host bit survives anything except a write to its register
    a_r3_host_sticky: assert property (@(posedge clk) disable iff (rst)
        (host_st[0] && !(wr_en && addr == {HOST_PAGE, 4'h0})) |=> host_st[0]);

    // R5: clear-on-read empties the register read
    a_r5_cor_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_en && cor_mode && addr == {MGMT_PAGE, 4'h0} && evt[DATA_W-1:0] == '0)
        |=> (mgmt_st[DATA_W-1:0] == '0));

    // R7: a frozen host bank keeps all non-source bits unchanged
    a_r7_host_frozen: assert property (@(posedge clk) disable iff (rst)
        (frz_a_en && host_st[SRC_A] && !wr_en)
        |=> ((host_st & KEEP) == ($past(host_st) & KEEP)));

    // R8: same for source B on the management bank without any access
    a_r8_mgmt_frozen: assert property (@(posedge clk) disable iff (rst)
        (frz_b_en && mgmt_st[SRC_B] && !wr_en && !rd_en)
        |=> ((mgmt_st & KEEP) == ($past(mgmt_st) & KEEP)));

    // R9: alert stays low while disabled
    a_r9_alert_gate: assert property (@(posedge clk) disable iff (rst)
        !alert_en_i |-> !alert_o);

    // R10 / R11: exported controls move only on a control write
    a_r10_ctl_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == CTL_ADDR) |=> ($stable(fan_full_o) && $stable(tach_edge_o)));

endmodule

bind dual_bank_errstat errstat_checker #(
    .NUM_REGS (NUM_REGS),
    .SRC_A    (SRC_A),
    .SRC_B    (SRC_B)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (reg_wr_en),
    .rd_en       (reg_rd_en),
    .addr        (reg_addr),
    .evt         (err_evt_i),
    .host_st     (host_flat),
    .mgmt_st     (mgmt_flat),
    .frz_a_en    (ctl.frz_a_en),
    .frz_b_en    (ctl.frz_b_en),
    .cor_mode    (ctl.cor_mode),
    .alert_en_i  (alert_en_i),
    .alert_o     (alert_o),
    .fan_full_o  (fan_full_o),
    .tach_edge_o (tach_edge_o)
);

// File: tb/dual_bank_errstat_tb_top.sv
module dual_bank_errstat_tb_top;

    localparam int NR = 4;
    localparam int W  = 8;
    localparam int N  = NR * W;
    localparam int A  = 12;
    localparam int B  = 13;

    logic         clk = 1'b0;
    logic         rst;
    logic         wr, rd, aen;
    logic [7:0]   addr, wd;
    logic [N-1:0] evt;
    logic [7:0]   rdata;
    logic         alert, fan;
    logic [1:0]   tach;

    always #10 clk = ~clk;

    dual_bank_errstat #(.NUM_REGS(NR), .SRC_A(A), .SRC_B(B)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .reg_wr_en   (wr),
        .reg_rd_en   (rd),
        .reg_addr    (addr),
        .reg_wdata   (wd),
        .reg_rdata   (rdata),
        .err_evt_i   (evt),
        .alert_en_i  (aen),
        .alert_o     (alert),
        .fan_full_o  (fan),
        .tach_edge_o (tach)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // behavioural reference state
    logic [N-1:0] mh, mm;
    logic [5:0]   mc;
    logic [7:0]   last_rd;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_rd(input logic [7:0] a);
        int i;
        i = int'(a[3:0]);
        if (a == 8'h00)                   return {(|mm), (|mh), mc};
        if (a[7:4] == 4'h1 && i < NR)     return mh[i*W +: W];
        if (a[7:4] == 4'h2 && i < NR)     return mm[i*W +: W];
        return 8'h00;
    endfunction

    function automatic string rd_tag(input logic [7:0] a);
        if (a == 8'h00)                          return "R1 ctl read";
        if (a[7:4] == 4'h1 && int'(a[3:0]) < NR) return "R3 host read";
        if (a[7:4] == 4'h2 && int'(a[3:0]) < NR) return "R4 mgmt read";
        return "R12 unmapped read";
    endfunction

    // one bus cycle; compares every output with the model, then advances it
    task automatic step(input bit w, input bit r, input logic [7:0] a,
                        input logic [7:0] d, input logic [N-1:0] e);
        logic [N-1:0] nh, nm;
        bit fh, fm, alw_h, alw_m, ch, cm;
        int ri;
        @(negedge clk);
        wr = w; rd = r; addr = a; wd = d; evt = e;
        #1;
        chk(rdata === model_rd(a), rd_tag(a), rdata, model_rd(a));
        chk(alert === ((|mm) && aen), "R9 alert", alert, (|mm) && aen);
        chk(fan === mc[3], "R10 fan", fan, mc[3]);
        chk(tach === mc[5:4], "R11 tach", tach, mc[5:4]);
        last_rd = rdata;
        fh = (mc[1] && mh[A]) || (mc[2] && mh[B]);
        fm = (mc[1] && mm[A]) || (mc[2] && mm[B]);
        for (int b = 0; b < N; b++) begin
            ri    = b / W;
            alw_h = !fh || (b == A && mc[1]) || (b == B && mc[2]);
            alw_m = !fm || (b == A && mc[1]) || (b == B && mc[2]);
            ch = w && a[7:4] == 4'h1 && int'(a[3:0]) == ri && d[b % W];
            if (mc[0])
                cm = r && a[7:4] == 4'h2 && int'(a[3:0]) == ri;
            else
                cm = w && a[7:4] == 4'h2 && int'(a[3:0]) == ri && d[b % W];
            nh[b] = (mh[b] && !ch) || (e[b] && alw_h);
            nm[b] = (mm[b] && !cm) || (e[b] && alw_m);
        end
        mh = nh;
        mm = nm;
        if (w && a == 8'h00) mc = d[5:0];
    endtask

    function automatic logic [N-1:0] bitv(input int k);
        logic [N-1:0] v;
        v = '0;
        v[k] = 1'b1;
        return v;
    endfunction

    task automatic idle(input logic [N-1:0] e);
        step(0, 0, 8'h7F, 8'h00, e);
    endtask

    task automatic rdx(input logic [7:0] a, input logic [7:0] exp, input string tag);
        step(0, 1, a, 8'h00, '0);
        chk(last_rd === exp, tag, last_rd, exp);
    endtask

    task automatic wrx(input logic [7:0] a, input logic [7:0] d);
        step(1, 0, a, d, '0);
    endtask

    task automatic clear_all();
        wrx(8'h00, 8'h00);
        for (int i = 0; i < NR; i++) begin
            wrx(8'h10 + 8'(i), 8'hFF);
            wrx(8'h20 + 8'(i), 8'hFF);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr = 0; rd = 0; aen = 0; addr = 0; wd = 0; evt = '0;
        mh = '0; mm = '0; mc = '0; last_rd = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rdx(8'h00, 8'h00, "R1 ctl after reset");
        rdx(8'h10, 8'h00, "R1 host after reset");
        rdx(8'h23, 8'h00, "R1 mgmt after reset");

        // R2 capture into both banks
        idle(bitv(0) | bitv(19));
        rdx(8'h10, 8'h01, "R2 host reg0");
        rdx(8'h22, 8'h08, "R2 mgmt reg2");

        // R3 host clear by write-one, reads do not clear
        rdx(8'h10, 8'h01, "R3 host read does not clear");
        wrx(8'h10, 8'h01);
        rdx(8'h10, 8'h00, "R3 host write-one clear");
        rdx(8'h20, 8'h01, "R4 mgmt untouched by host write");
        rdx(8'h00, 8'hC0, "R9 both summaries set");
        wrx(8'h00, 8'hC0);
        rdx(8'h00, 8'hC0, "R9 summary write ignored");

        // R4 mgmt write-one clear mode
        wrx(8'h20, 8'h01);
        rdx(8'h20, 8'h00, "R4 mgmt write-one clear");

        // R5 clear-on-read mode
        wrx(8'h00, 8'h01);
        idle(bitv(29));
        wrx(8'h23, 8'hFF);
        rdx(8'h23, 8'h20, "R5 cor read returns value");
        rdx(8'h23, 8'h00, "R5 cor read cleared");
        rdx(8'h22, 8'h08, "R5 cor reg2");
        rdx(8'h22, 8'h00, "R5 cor reg2 cleared");

        // R6 set beats clear
        idle(bitv(10));
        step(1, 0, 8'h11, 8'h04, bitv(10));
        rdx(8'h11, 8'h04, "R6 host set wins over write clear");
        step(0, 1, 8'h21, 8'h00, bitv(10));
        rdx(8'h21, 8'h04, "R6 mgmt set wins over read clear");

        // R7 freeze on source A
        clear_all();
        wrx(8'h00, 8'h02);
        idle(bitv(A));
        idle(bitv(1));
        rdx(8'h10, 8'h00, "R7 host frozen");
        rdx(8'h20, 8'h00, "R7 mgmt frozen");
        idle(bitv(B));
        rdx(8'h11, 8'h10, "R7 unarmed source B ignored");
        wrx(8'h11, 8'h10);
        idle(bitv(1));
        rdx(8'h10, 8'h02, "R7 host released after clear");
        rdx(8'h20, 8'h00, "R7 mgmt still frozen");
        wrx(8'h21, 8'h10);
        idle(bitv(1));
        rdx(8'h20, 8'h02, "R7 mgmt released");

        // R8 freeze on source B
        clear_all();
        wrx(8'h00, 8'h04);
        idle(bitv(B));
        idle(bitv(2));
        rdx(8'h10, 8'h00, "R8 host frozen by B");
        idle(bitv(A));
        rdx(8'h11, 8'h20, "R8 unarmed source A ignored");
        wrx(8'h00, 8'h06);
        idle(bitv(A));
        rdx(8'h11, 8'h30, "R8 armed source A captured while frozen");
        rdx(8'h21, 8'h30, "R8 mgmt source bits");

        // R9 alert gating
        clear_all();
        aen = 1'b1;
        idle(bitv(16));
        idle('0);
        chk(alert === 1'b1, "R9 alert asserted", alert, 1);
        wrx(8'h12, 8'h01);
        rdx(8'h00, 8'h80, "R9 only mgmt summary");
        aen = 1'b0;
        idle('0);
        chk(alert === 1'b0, "R9 alert disabled", alert, 0);
        aen = 1'b1;
        wrx(8'h22, 8'h01);
        idle('0);
        chk(alert === 1'b0, "R9 alert clears with bank", alert, 0);

        // R10 / R11 exported controls
        wrx(8'h00, 8'h38);
        idle('0);
        chk(fan === 1'b1, "R10 fan full on", fan, 1);
        chk(tach === 2'b11, "R11 tach reserved code", tach, 3);
        wrx(8'h00, 8'h10);
        idle('0);
        chk(fan === 1'b0, "R10 fan full off", fan, 0);
        chk(tach === 2'b01, "R11 tach rising", tach, 1);
        wrx(8'h00, 8'h20);
        idle('0);
        chk(tach === 2'b10, "R11 tach falling", tach, 2);

        // R12 unmapped addresses
        idle(bitv(31));
        rdx(8'h14, 8'h00, "R12 host index beyond range");
        rdx(8'h05, 8'h00, "R12 stray address");
        rdx(8'h13, 8'h80, "R2 top bit");

        done = 1'b1;
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule